// File: doc/BRIEF.md
# Masked Bus Event Trigger Latch

This block watches the pins of an emulated memory device (address and data together) and recognises a bus cycle whose pin values fit a programmed pattern. Each pin has a polarity bit that chooses the level it must have and a care bit that can take it out of the compare. A separate device-select term also takes part in the compare. It reports that the emulated device has both chip enable and output enable active, and it has its own care bit. The combined result is available at once as an active-low equal signal.

An active-low bus-cycle strobe is synchronised into the block clock. On each falling edge of that strobe the equal signal is sampled. A hit sets a sticky event flag, which then holds until an asynchronous reset or a synchronous rearm clears it. Pattern registers are loaded through a small write port. After reset every term is a don't-care, so the first strobe after reset sets the flag.

Top module: `evt_match_latch`

## Requirements
- R1: A pin whose care bit is 1 satisfies its term only when its level equals its polarity bit.
- R2: A pin whose care bit is 0 always satisfies its term, whatever its level or polarity bit.
- R3: When the select care bit is 1, the select term is satisfied only while `dev_sel_n` is 0. When that bit is 0, `dev_sel_n` has no effect on the compare.
- R4: `cmp_eq_n` is 0 exactly when every pin term and the select term are satisfied. It follows pin changes in the same cycle, with no clock in the path.
- R5: `evt_flag` sets only at a synchronised falling edge of `cyc_strb_n` while `cmp_eq_n` is 0. It rises on the third rising clock edge after `cyc_strb_n` goes low. A strobe edge that finds no match leaves the flag clear.
- R6: Once set, `evt_flag` stays 1 whatever later compare results and strobes do, until it is cleared.
- R7: `rst_n` low clears `evt_flag` at once. `rearm` high at a rising clock edge clears it at that edge.
- R8: If `rearm` is high at the same edge where a matching strobe sample would set the flag, the flag stays 0.
- R9: Each strobe low period is captured once. Holding `cyc_strb_n` low or returning it high causes no further capture.
- R10: After reset the flag is 0, all polarity, care and select-care bits are 0, and the first strobe after reset sets the flag.
- R11: The write port loads a register at a rising edge with `cfg_we` 1. `cfg_sel` 0 selects polarity, 1 selects care, and 2 selects the select care bit (bit 0 of `cfg_wdata`). `cfg_sel` 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Pattern register write enable |
| cfg_sel | input | 2 | Register select: 0 polarity, 1 care, 2 select care, 3 none |
| cfg_wdata | input | PIN_W | Write data |
| pins | input | PIN_W | Monitored address and data pins |
| dev_sel_n | input | 1 | Active low when device chip enable and output enable are both active |
| cyc_strb_n | input | 1 | Active-low bus-cycle strobe, asynchronous |
| rearm | input | 1 | Synchronous clear of the event flag |
| cmp_eq_n | output | 1 | Active-low combinational match |
| evt_flag | output | 1 | Sticky event flag |

## Verification
A wrong pattern register or term shows as a wrong `cmp_eq_n` in the same cycle as the pin or configuration change. The bench compares that signal against a model after every random stimulus. A fault in the strobe synchroniser or edge detector shows at `evt_flag` on the third clock edge after the strobe falls: a capture that comes late, twice, or at the strobe's rising edge. A broken hold or clear path in the flag shows as a drop or a missed clear one cycle after the matching strobe, `rearm` or reset. The rearm-against-capture collision is driven on the exact capture edge.

// File: rtl/evt_match_pkg.sv
package evt_match_pkg;

   typedef enum logic [1:0] {
      CFG_POL   = 2'd0,
      CFG_CARE  = 2'd1,
      CFG_SELC  = 2'd2,
      CFG_NONE  = 2'd3
   } cfg_sel_e;

   function automatic int unsigned ceil_div(input int unsigned a, input int unsigned b);
      return (a + b - 1) / b;
   endfunction

endpackage

// File: rtl/evt_pattern_regs.sv
module evt_pattern_regs
   import evt_match_pkg::*;
#(
   parameter int unsigned PIN_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [1:0]       sel,
   input  logic [PIN_W-1:0] wdata,
   output logic [PIN_W-1:0] pol_q,
   output logic [PIN_W-1:0] care_q,
   output logic             selc_q
);

   if (PIN_W < 1) begin : g_bad_width
      $error("evt_pattern_regs: PIN_W must be at least 1");
   end

   logic wr_pol, wr_care, wr_selc;

   always_comb begin
      wr_pol  = we && (cfg_sel_e'(sel) == CFG_POL);
      wr_care = we && (cfg_sel_e'(sel) == CFG_CARE);
      wr_selc = we && (cfg_sel_e'(sel) == CFG_SELC);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pol_q  <= '0;
         care_q <= '0;
         selc_q <= 1'b0;
      end else begin
         if (wr_pol)  pol_q  <= wdata;
         if (wr_care) care_q <= wdata;
         if (wr_selc) selc_q <= wdata[0];
      end
   end

endmodule

// File: rtl/evt_pin_compare.sv
module evt_pin_compare
   import evt_match_pkg::*;
#(
   parameter int unsigned PIN_W   = 32,
   parameter int unsigned GROUP_W = 8
) (
   input  logic [PIN_W-1:0] pins,
   input  logic [PIN_W-1:0] pol,
   input  logic [PIN_W-1:0] care,
   input  logic             dev_sel_n,
   input  logic             selc,
   output logic             eq_n
);

   localparam int unsigned NGRP  = ceil_div(PIN_W, GROUP_W);
   localparam int unsigned PAD_W = NGRP * GROUP_W;

   if (GROUP_W < 1 || GROUP_W > PIN_W) begin : g_bad_group
      $error("evt_pin_compare: GROUP_W must be within 1..PIN_W");
   end

   logic [PAD_W-1:0] term_ok;
   logic [NGRP-1:0]  grp_ok;
   logic             sel_ok;

   // per-pin term: ignored when care is 0, else level must equal polarity
   for (genvar i = 0; i < PAD_W; i++) begin : g_term
      if (i < PIN_W) begin : g_real
         assign term_ok[i] = !care[i] || (pins[i] == pol[i]);
      end else begin : g_pad
         assign term_ok[i] = 1'b1;
      end
   end

   // grouped reduction keeps the final AND narrow for wide pin sets
   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      assign grp_ok[g] = &term_ok[g*GROUP_W +: GROUP_W];
   end

   assign sel_ok = !selc || !dev_sel_n;
   assign eq_n   = !(sel_ok && (&grp_ok));

endmodule

// File: rtl/evt_strobe_sync.sv
module evt_strobe_sync #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strb_n,
   output logic sample
);

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("evt_strobe_sync: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '1;
         prev_q <= 1'b1;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], strb_n};
         prev_q <= sync_q[SYNC_STAGES-1];
      end
   end

   // one pulse per high-to-low transition of the synchronised strobe
   assign sample = prev_q && !sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/evt_flag_latch.sv
module evt_flag_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic sample,
   input  logic eq_n,
   input  logic rearm,
   output logic flag
);

   logic hit;
   assign hit = sample && !eq_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag <= 1'b0;
      else if (rearm) flag <= 1'b0;
      else            flag <= flag || hit;
   end

endmodule

// File: rtl/evt_match_latch.sv
module evt_match_latch
   import evt_match_pkg::*;
#(
   parameter int unsigned PIN_W       = 32,
   parameter int unsigned GROUP_W     = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [1:0]       cfg_sel,
   input  logic [PIN_W-1:0] cfg_wdata,
   input  logic [PIN_W-1:0] pins,
   input  logic             dev_sel_n,
   input  logic             cyc_strb_n,
   input  logic             rearm,
   output logic             cmp_eq_n,
   output logic             evt_flag
);

   logic [PIN_W-1:0] pol_q, care_q;
   logic             selc_q;
   logic             smp;

   evt_pattern_regs #(.PIN_W(PIN_W)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (cfg_we),
      .sel    (cfg_sel),
      .wdata  (cfg_wdata),
      .pol_q  (pol_q),
      .care_q (care_q),
      .selc_q (selc_q)
   );

   evt_pin_compare #(.PIN_W(PIN_W), .GROUP_W(GROUP_W)) u_cmp (
      .pins      (pins),
      .pol       (pol_q),
      .care      (care_q),
      .dev_sel_n (dev_sel_n),
      .selc      (selc_q),
      .eq_n      (cmp_eq_n)
   );

   evt_strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .strb_n (cyc_strb_n),
      .sample (smp)
   );

   evt_flag_latch u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .sample (smp),
      .eq_n   (cmp_eq_n),
      .rearm  (rearm),
      .flag   (evt_flag)
   );

endmodule

// File: rtl/evt_match_checker.sv
module evt_match_checker #(
   parameter int unsigned PIN_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rearm,
   input logic             dev_sel_n,
   input logic             cmp_eq_n,
   input logic             evt_flag,
   input logic             smp,
   input logic [PIN_W-1:0] care_q,
   input logic             selc_q
);

   p_flag_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_flag && !rearm) |=> evt_flag);

   p_rearm_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rearm |=> !evt_flag);

   p_rearm_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rearm && smp && !cmp_eq_n) |=> !evt_flag);

   p_set_needs_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(evt_flag) |-> ($past(!cmp_eq_n) && $past(smp)));

   p_no_set_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt_flag && !smp) |=> !evt_flag);

   p_sel_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (selc_q && dev_sel_n) |-> cmp_eq_n);

   p_all_dontcare_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (care_q == '0 && !selc_q) |-> !cmp_eq_n);

endmodule

bind evt_match_latch evt_match_checker #(.PIN_W(PIN_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rearm     (rearm),
   .dev_sel_n (dev_sel_n),
   .cmp_eq_n  (cmp_eq_n),
   .evt_flag  (evt_flag),
   .smp       (smp),
   .care_q    (care_q),
   .selc_q    (selc_q)
);

// File: tb/sim_evt_match_latch.sv
`timescale 1ns/1ps
module sim_evt_match_latch;

   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cfg_we = 1'b0;
   logic [1:0]   cfg_sel = 2'd0;
   logic [W-1:0] cfg_wdata = '0;
   logic [W-1:0] pins = '0;
   logic         dev_sel_n = 1'b1;
   logic         cyc_strb_n = 1'b1;
   logic         rearm = 1'b0;
   logic         cmp_eq_n;
   logic         evt_flag;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [W-1:0] m_pol = '0, m_care = '0;
   logic         m_selc = 1'b0;
   logic         m_flag = 1'b0;

   always #2.5 clk = ~clk;

   evt_match_latch #(.PIN_W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .pins(pins), .dev_sel_n(dev_sel_n),
      .cyc_strb_n(cyc_strb_n), .rearm(rearm), .cmp_eq_n(cmp_eq_n),
      .evt_flag(evt_flag)
   );

   function automatic logic exp_eq_n(input logic [W-1:0] p, input logic sn);
      logic ok;
      ok = 1'b1;
      for (int i = 0; i < W; i++)
         if (m_care[i] && (p[i] != m_pol[i])) ok = 1'b0;
      if (m_selc && sn) ok = 1'b0;
      return !ok;
   endfunction

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wr(input logic [1:0] s, input logic [W-1:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      case (s)
         2'd0: m_pol = d;
         2'd1: m_care = d;
         2'd2: m_selc = d[0];
         default: ;
      endcase
   endtask

   task automatic drive(input logic [W-1:0] p, input logic sn);
      @(negedge clk);
      pins = p; dev_sel_n = sn;
      #1;
      chk("R4 compare", cmp_eq_n, exp_eq_n(p, sn));
   endtask

   task automatic strobe();
      @(negedge clk);
      cyc_strb_n = 1'b0;
      if (!exp_eq_n(pins, dev_sel_n)) m_flag = 1'b1;
      repeat (4) @(negedge clk);
      cyc_strb_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic do_rearm();
      @(negedge clk);
      rearm = 1'b1;
      @(negedge clk);
      rearm = 1'b0;
      m_flag = 1'b0;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1234_5678));
      pins = 32'hDEAD_BEEF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: reset state
      chk("R10 flag after reset", evt_flag, 1'b0);
      chk("R10 all dont-care match", cmp_eq_n, 1'b0);
      strobe();
      chk("R10 first strobe sets flag", evt_flag, 1'b1);
      do_rearm();
      chk("R7 rearm clears", evt_flag, 1'b0);

      // R1 polarity
      wr(2'd0, 32'hA5A5_0F0F);
      wr(2'd1, 32'hFFFF_FFFF);
      drive(32'hA5A5_0F0F, 1'b1);
      chk("R1 exact match", cmp_eq_n, 1'b0);
      drive(32'hA5A5_0F0E, 1'b1);
      chk("R1 one bit off", cmp_eq_n, 1'b1);

      // R2 masked pin ignored
      wr(2'd1, 32'hFFFF_FFFE);
      drive(32'hA5A5_0F0E, 1'b1);
      chk("R2 masked bit ignored", cmp_eq_n, 1'b0);

      // R3 select term
      wr(2'd2, 32'h1);
      drive(32'hA5A5_0F0F, 1'b1);
      chk("R3 select required", cmp_eq_n, 1'b1);
      drive(32'hA5A5_0F0F, 1'b0);
      chk("R3 select active", cmp_eq_n, 1'b0);
      wr(2'd2, 32'h0);
      drive(32'hA5A5_0F0F, 1'b1);
      chk("R3 select dont-care", cmp_eq_n, 1'b0);

      // R11 sel 3 writes nothing
      wr(2'd3, 32'h0000_0000);
      drive(32'h0000_0000, 1'b1);
      chk("R11 sel3 no effect", cmp_eq_n, 1'b1);

      // R5 non-match strobe leaves flag clear; exact capture edge
      strobe();
      chk("R5 no match no set", evt_flag, 1'b0);
      drive(32'hA5A5_0F0F, 1'b1);
      @(negedge clk);
      cyc_strb_n = 1'b0;
      repeat (2) @(negedge clk);
      chk("R5 not yet after two edges", evt_flag, 1'b0);
      @(negedge clk);
      chk("R5 set on third edge", evt_flag, 1'b1);
      m_flag = 1'b1;
      cyc_strb_n = 1'b1;
      repeat (4) @(negedge clk);

      // R6 sticky across non-matching strobes
      drive(32'h0, 1'b1);
      strobe();
      chk("R6 flag holds", evt_flag, 1'b1);

      // R7 async reset clears
      #1 rst_n = 1'b0;
      #1 chk("R7 reset clears at once", evt_flag, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      m_pol = '0; m_care = '0; m_selc = 1'b0; m_flag = 1'b0;

      // R8 rearm at capture edge wins
      drive(32'h1234_5678, 1'b1);
      @(negedge clk);
      cyc_strb_n = 1'b0;
      repeat (2) @(negedge clk);
      rearm = 1'b1;
      @(negedge clk);
      rearm = 1'b0;
      repeat (3) @(negedge clk);
      chk("R8 rearm wins collision", evt_flag, 1'b0);
      // R9 held-low strobe and its rising edge cause no capture
      cyc_strb_n = 1'b1;
      repeat (5) @(negedge clk);
      chk("R9 no capture on release", evt_flag, 1'b0);

      // random stimulus
      for (int n = 0; n < 150; n++) begin
         logic [W-1:0] rp, rc, pv;
         rp = $urandom;
         rc = $urandom & $urandom & $urandom;
         wr(2'd0, rp);
         wr(2'd1, rc);
         wr(2'd2, {31'd0, 1'($urandom)});
         pv = (($urandom % 2) == 0) ? (rp ^ ($urandom & ~rc)) : $urandom;
         drive(pv, 1'($urandom));
         if (($urandom % 4) == 0) begin
            do_rearm();
            chk("R7 random rearm", evt_flag, 1'b0);
         end
         if (($urandom % 3) == 0) begin
            strobe();
            chk("R5 R6 random flag", evt_flag, m_flag);
         end
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule